// File: doc/BRIEF.md
# Multichannel TDM Synchronous Serial Port

This block is a synchronous serial port with a receive section and a transmit section that share one serial clock and one frame-sync input. Each section moves words of 3 to 16 bits, most significant bit first. The serial clock comes from one of two places. It can be made inside the block by dividing the system clock, and the block then drives it out on a pin. It can also be taken from an external pin, in which case the block oversamples it in the system clock domain. On the host side there is a parallel word interface. Received words appear on a data bus together with a one-cycle completion pulse. Words to transmit are written into a one-entry holding register. The transmit section also gives a per-word completion pulse and a sticky underrun flag.

In plain mode, each frame-sync pulse starts exactly one word. In multichannel mode, one frame-sync pulse marks slot 0 of a time-division-multiplexed frame of 24 or 32 slots. After that first pulse, the slot counter runs on by itself and wraps back to slot 0 after the last slot. A 32-bit receive mask and a 32-bit transmit mask pick which slots are captured and which are driven. The transmit pin is released (output enable low) during slots that are not selected.

Top module: `sport_tdm`

## Requirements
- R1: The word length is `cfg_wlen_m1 + 1` and may be any value from 3 to 16. A `cfg_wlen_m1` value of 0 or 1 is treated as 2.
- R2: With `cfg_int_clk` = 1, `sclk_o` is a divided clock with a period of 2*(`cfg_div`+1) system clocks, and `sclk_oe` is 1. With `cfg_int_clk` = 0, `sclk_oe` is 0.
- R3: The receive section samples `rx_sd_i` on rising serial-clock edges, MSB first. When the last bit of a word is sampled, `rx_data_o` takes the word, right-justified with its upper bits zero, and `rx_irq_o` pulses high for exactly one system clock.
- R4: `tx_sd_o` changes only on falling serial-clock edges. It sends the loaded word MSB first, and the MSB is driven on the falling edge that follows the rising edge on which the frame sync was seen. `tx_irq_o` pulses for one system clock when the last bit of a driven word completes.
- R5: `fs_i` is sampled on rising serial-clock edges. A high sample means the MSB of a word arrives on the next rising edge. In plain mode (`cfg_mc_en` = 0), each frame sync produces exactly one word, after which the port idles.
- R6: With `cfg_mc_en` = 1, one frame sync marks slot 0 and the following words fill slots 1, 2, and so on without further syncs. The last slot is 31 when `cfg_mc_32` = 1 and 23 when it is 0, and after the last slot the counter wraps to slot 0.
- R7: In multichannel mode, a word in slot i is captured only if `rx_mask[i]` = 1. An unselected word produces no `rx_irq_o` and leaves `rx_data_o` unchanged.
- R8: In multichannel mode, `tx_sd_oe` is 1 during slot i only if `tx_mask[i]` = 1. An unselected slot consumes no word and raises no `tx_irq_o`. In plain mode, `tx_sd_oe` is 1 for the whole word.
- R9: If a word must be loaded for transmission and the holding register is empty, the last written word is sent again and `tx_underrun_o` is set. The flag then stays set until reset.
- R10: A host write (`tx_wr_i`) in the same cycle as a transmit load works as follows. If the holding register is full, the old word is sent and the new word stays held. If it is empty, the new word is sent directly and no underrun is flagged.
- R11: With `cfg_int_clk` = 0, the port shifts against `sclk_i` with the same bit order and framing as with the internal clock.
- R12: After reset, `rx_irq_o`, `tx_irq_o`, `tx_sd_oe`, `tx_underrun_o` and `sclk_o` are 0 and `rx_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_int_clk | input | 1 | 1: internal serial clock, 0: external `sclk_i` |
| cfg_div | input | 8 | Internal clock divider N, period 2*(N+1) |
| cfg_wlen_m1 | input | 4 | Word length minus one |
| cfg_mc_en | input | 1 | Multichannel TDM mode enable |
| cfg_mc_32 | input | 1 | 1: 32-slot frame, 0: 24-slot frame |
| rx_mask | input | 32 | Receive slot select, bit i for slot i |
| tx_mask | input | 32 | Transmit slot select, bit i for slot i |
| sclk_i | input | 1 | External serial clock |
| sclk_o | output | 1 | Internally generated serial clock |
| sclk_oe | output | 1 | Serial clock pin drive enable |
| fs_i | input | 1 | Frame sync |
| rx_sd_i | input | 1 | Serial receive data |
| tx_sd_o | output | 1 | Serial transmit data |
| tx_sd_oe | output | 1 | Transmit data drive enable |
| rx_data_o | output | 16 | Last captured word |
| rx_irq_o | output | 1 | Receive word complete pulse |
| tx_data_i | input | 16 | Word to transmit |
| tx_wr_i | input | 1 | Write strobe for `tx_data_i` |
| tx_irq_o | output | 1 | Transmit word complete pulse |
| tx_underrun_o | output | 1 | Sticky transmit underrun flag |

## Verification
The case that needs the most care is a host write that lands in the same system clock as the transmit shifter loading its next word. The bench provokes it with the internal clock. It counts system clocks from a falling serial edge so that `tx_wr_i` is high exactly on the rising edge that samples the frame sync. It does this twice: once with the holding register already full, and once with it empty. The bench judges the outcome from the serial bits that follow, from the word sent in the next frame, and from `tx_underrun_o`, which must stay low in both orderings.

// File: rtl/sport_pkg.sv
package sport_pkg;
    localparam int WORD_MAX_DEF = 16;
    localparam int SLOT_MAX_DEF = 32;
    localparam int SLOT_ALT_DEF = 24;
    localparam int DIV_W_DEF    = 8;

    typedef enum logic {
        CLK_EXT = 1'b0,
        CLK_INT = 1'b1
    } clk_src_e;
endpackage

// File: rtl/sport_clkgen.sv
module sport_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_mode,
    input  logic [DIV_W-1:0] div,
    input  logic             sclk_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o
);
    import sport_pkg::*;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
        logic             s1;
        logic             s2;
        logic             s3;
    } st_t;

    st_t  st_d, st_q;
    logic tick;
    logic ext_rise, ext_fall;
    clk_src_e src;

    always_comb begin
        src      = clk_src_e'(int_mode);
        tick     = (st_q.cnt == div);
        ext_rise = st_q.s2 & ~st_q.s3;
        ext_fall = ~st_q.s2 & st_q.s3;
        st_d     = st_q;
        st_d.s1  = sclk_i;
        st_d.s2  = st_q.s1;
        st_d.s3  = st_q.s2;
        if (tick) begin
            st_d.cnt  = '0;
            st_d.sclk = ~st_q.sclk;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (src == CLK_INT) begin
            rise_o = tick & ~st_q.sclk;
            fall_o = tick & st_q.sclk;
        end else begin
            rise_o = ext_rise;
            fall_o = ext_fall;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk_o = st_q.sclk;
endmodule

// File: rtl/sport_seq.sv
module sport_seq #(
    parameter int BIT_W  = 4,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fs,
    input  logic [BIT_W-1:0]  wlen,
    input  logic              mc_en,
    input  logic [SLOT_W-1:0] last_slot,
    output logic              active,
    output logic [BIT_W-1:0]  bitc,
    output logic [SLOT_W-1:0] slot,
    output logic              word_end,
    output logic              start,
    output logic [SLOT_W-1:0] next_slot
);
    typedef struct packed {
        logic              active;
        logic [BIT_W-1:0]  bitc;
        logic [SLOT_W-1:0] slot;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        word_end = rise && st_q.active && (st_q.bitc == wlen);
        if (fs || (st_q.slot == last_slot)) next_slot = '0;
        else                                next_slot = st_q.slot + 1'b1;
        start = rise && (fs || (word_end && mc_en));
        st_d  = st_q;
        if (rise) begin
            if (fs) begin
                st_d.active = 1'b1;
                st_d.bitc   = '0;
                st_d.slot   = '0;
            end else if (word_end) begin
                st_d.bitc = '0;
                if (mc_en) st_d.slot   = next_slot;
                else       st_d.active = 1'b0;
            end else if (st_q.active) begin
                st_d.bitc = st_q.bitc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
    assign bitc   = st_q.bitc;
    assign slot   = st_q.slot;
endmodule

// File: rtl/sport_rx.sv
module sport_rx #(
    parameter int WORD_MAX = 16,
    parameter int BIT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise,
    input  logic                active,
    input  logic [BIT_W-1:0]    bitc,
    input  logic                word_end,
    input  logic                slot_en,
    input  logic                sd,
    output logic [WORD_MAX-1:0] data_o,
    output logic                irq_o
);
    typedef struct packed {
        logic [WORD_MAX-1:0] sr;
        logic [WORD_MAX-1:0] data;
        logic                irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (rise && active) begin
            if (bitc == '0) st_d.sr = {{(WORD_MAX-1){1'b0}}, sd};
            else            st_d.sr = {st_q.sr[WORD_MAX-2:0], sd};
            if (word_end && slot_en) begin
                st_d.data = st_d.sr;
                st_d.irq  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/sport_tx.sv
module sport_tx #(
    parameter int WORD_MAX = 16,
    parameter int BIT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise,
    input  logic                fall,
    input  logic                active,
    input  logic [BIT_W-1:0]    bitc,
    input  logic [BIT_W-1:0]    wlen,
    input  logic                start,
    input  logic                en_next,
    input  logic                word_end,
    input  logic                wr,
    input  logic [WORD_MAX-1:0] wdata,
    output logic                sd_o,
    output logic                oe_o,
    output logic                irq_o,
    output logic                urun_o
);
    typedef struct packed {
        logic [WORD_MAX-1:0] hold;
        logic                full;
        logic [WORD_MAX-1:0] word;
        logic                cur_en;
        logic                sd;
        logic                oe;
        logic                irq;
        logic                urun;
    } st_t;

    st_t  st_d, st_q;
    logic load;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        load     = start && en_next;

        if (rise && word_end && st_q.cur_en) st_d.irq = 1'b1;

        if (start) st_d.cur_en = en_next;

        if (load) begin
            if (st_q.full) begin
                st_d.word = st_q.hold;
                st_d.full = 1'b0;
            end else if (wr) begin
                st_d.word = wdata;
            end else begin
                st_d.word = st_q.hold;
                st_d.urun = 1'b1;
            end
        end

        if (wr) begin
            st_d.hold = wdata;
            st_d.full = !(load && !st_q.full);
        end

        if (fall) begin
            st_d.sd = st_q.word[wlen - bitc];
            st_d.oe = active && st_q.cur_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sd_o   = st_q.sd;
    assign oe_o   = st_q.oe;
    assign irq_o  = st_q.irq;
    assign urun_o = st_q.urun;
endmodule

// File: rtl/sport_tdm.sv
module sport_tdm #(
    parameter int WORD_MAX = sport_pkg::WORD_MAX_DEF,
    parameter int SLOT_MAX = sport_pkg::SLOT_MAX_DEF,
    parameter int SLOT_ALT = sport_pkg::SLOT_ALT_DEF,
    parameter int DIV_W    = sport_pkg::DIV_W_DEF,
    localparam int BIT_W   = $clog2(WORD_MAX),
    localparam int SLOT_W  = $clog2(SLOT_MAX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_int_clk,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic [BIT_W-1:0]    cfg_wlen_m1,
    input  logic                cfg_mc_en,
    input  logic                cfg_mc_32,
    input  logic [SLOT_MAX-1:0] rx_mask,
    input  logic [SLOT_MAX-1:0] tx_mask,
    input  logic                sclk_i,
    output logic                sclk_o,
    output logic                sclk_oe,
    input  logic                fs_i,
    input  logic                rx_sd_i,
    output logic                tx_sd_o,
    output logic                tx_sd_oe,
    output logic [WORD_MAX-1:0] rx_data_o,
    output logic                rx_irq_o,
    input  logic [WORD_MAX-1:0] tx_data_i,
    input  logic                tx_wr_i,
    output logic                tx_irq_o,
    output logic                tx_underrun_o
);
    localparam logic [SLOT_W-1:0] LAST_FULL = SLOT_W'(SLOT_MAX - 1);
    localparam logic [SLOT_W-1:0] LAST_ALT  = SLOT_W'(SLOT_ALT - 1);
    localparam logic [BIT_W-1:0]  WLEN_MIN  = BIT_W'(2);

    logic              rise, fall;
    logic [BIT_W-1:0]  wlen;
    logic [SLOT_W-1:0] last_slot;
    logic              active, word_end, start;
    logic [BIT_W-1:0]  bitc;
    logic [SLOT_W-1:0] slot, next_slot;
    logic              rx_en, tx_en_next;

    always_comb begin
        wlen       = (cfg_wlen_m1 < WLEN_MIN) ? WLEN_MIN : cfg_wlen_m1;
        last_slot  = cfg_mc_32 ? LAST_FULL : LAST_ALT;
        rx_en      = !cfg_mc_en || rx_mask[slot];
        tx_en_next = !cfg_mc_en || tx_mask[next_slot];
    end

    assign sclk_oe = cfg_int_clk;

    sport_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .int_mode(cfg_int_clk), .div(cfg_div),
        .sclk_i(sclk_i), .sclk_o(sclk_o), .rise_o(rise), .fall_o(fall)
    );

    sport_seq #(.BIT_W(BIT_W), .SLOT_W(SLOT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fs(fs_i), .wlen(wlen),
        .mc_en(cfg_mc_en), .last_slot(last_slot), .active(active),
        .bitc(bitc), .slot(slot), .word_end(word_end), .start(start),
        .next_slot(next_slot)
    );

    sport_rx #(.WORD_MAX(WORD_MAX), .BIT_W(BIT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rise(rise), .active(active), .bitc(bitc),
        .word_end(word_end), .slot_en(rx_en), .sd(rx_sd_i),
        .data_o(rx_data_o), .irq_o(rx_irq_o)
    );

    sport_tx #(.WORD_MAX(WORD_MAX), .BIT_W(BIT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .active(active),
        .bitc(bitc), .wlen(wlen), .start(start), .en_next(tx_en_next),
        .word_end(word_end), .wr(tx_wr_i), .wdata(tx_data_i),
        .sd_o(tx_sd_o), .oe_o(tx_sd_oe), .irq_o(tx_irq_o),
        .urun_o(tx_underrun_o)
    );
endmodule

// File: rtl/sport_tdm_chk.sv
module sport_tdm_chk #(
    parameter int WORD_MAX = 16,
    parameter int BIT_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_int_clk,
    input logic [BIT_W-1:0]    cfg_wlen_m1,
    input logic                sclk_o,
    input logic                tx_sd_oe,
    input logic [WORD_MAX-1:0] rx_data_o,
    input logic                rx_irq_o,
    input logic                tx_underrun_o
);
    logic       past_ok;
    logic [5:0] keep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb keep = (cfg_wlen_m1 < BIT_W'(2)) ? 6'd3 : ({2'b00, cfg_wlen_m1} + 6'd1);

    p_rx_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_o |=> !rx_irq_o);

    p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_o |-> ((32'(rx_data_o) >> keep) == 32'd0));

    p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !rx_irq_o) |-> $stable(rx_data_o));

    p_urun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun_o |=> tx_underrun_o);

    p_oe_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && cfg_int_clk && $past(cfg_int_clk) && !$stable(tx_sd_oe)) |-> !sclk_o);
endmodule

bind sport_tdm sport_tdm_chk #(.WORD_MAX(WORD_MAX), .BIT_W(BIT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_int_clk(cfg_int_clk),
    .cfg_wlen_m1(cfg_wlen_m1), .sclk_o(sclk_o), .tx_sd_oe(tx_sd_oe),
    .rx_data_o(rx_data_o), .rx_irq_o(rx_irq_o), .tx_underrun_o(tx_underrun_o)
);

// File: tb/tb_sport_tdm.sv
module tb_sport_tdm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_int_clk = 1'b1;
    logic [7:0]  cfg_div = 8'd2;
    logic [3:0]  cfg_wlen_m1 = 4'd7;
    logic        cfg_mc_en = 1'b0;
    logic        cfg_mc_32 = 1'b0;
    logic [31:0] rx_mask = '0;
    logic [31:0] tx_mask = '0;
    logic        sclk_ext = 1'b0;
    logic        sclk_o, sclk_oe;
    logic        fs_i = 1'b0;
    logic        rx_sd_i = 1'b0;
    logic        tx_sd_o, tx_sd_oe;
    logic [15:0] rx_data_o;
    logic        rx_irq_o;
    logic [15:0] tx_data_i = '0;
    logic        tx_wr_i = 1'b0;
    logic        tx_irq_o, tx_underrun_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_txirq = 0;
    logic [15:0] rx_exp[$];
    logic [15:0] rx_words[32];
    logic [15:0] tx_words[32];

    wire bclk = cfg_int_clk ? sclk_o : sclk_ext;

    always #2.5 clk = ~clk;
    always #40 sclk_ext = ~sclk_ext;
    always @(posedge clk) cyc <= cyc + 1;

    sport_tdm dut (
        .clk(clk), .rst_n(rst_n), .cfg_int_clk(cfg_int_clk), .cfg_div(cfg_div),
        .cfg_wlen_m1(cfg_wlen_m1), .cfg_mc_en(cfg_mc_en), .cfg_mc_32(cfg_mc_32),
        .rx_mask(rx_mask), .tx_mask(tx_mask), .sclk_i(sclk_ext), .sclk_o(sclk_o),
        .sclk_oe(sclk_oe), .fs_i(fs_i), .rx_sd_i(rx_sd_i), .tx_sd_o(tx_sd_o),
        .tx_sd_oe(tx_sd_oe), .rx_data_o(rx_data_o), .rx_irq_o(rx_irq_o),
        .tx_data_i(tx_data_i), .tx_wr_i(tx_wr_i), .tx_irq_o(tx_irq_o),
        .tx_underrun_o(tx_underrun_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor for received words (R3, R7)
    always @(negedge clk) begin
        if (rst_n && rx_irq_o) begin
            if (rx_exp.size() == 0) begin
                chk(1'b0, "R7 unexpected rx word", 32'(rx_data_o), 32'hFFFF_FFFF);
            end else begin
                logic [15:0] e;
                e = rx_exp.pop_front();
                chk(rx_data_o == e, "R3 rx word", 32'(rx_data_o), 32'(e));
            end
        end
        if (rst_n && tx_irq_o) n_txirq++;
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    task automatic host_write(input logic [15:0] w);
        @(negedge clk);
        tx_wr_i = 1'b1;
        tx_data_i = w;
        @(negedge clk);
        tx_wr_i = 1'b0;
    endtask

    // drives one frame; in multichannel mode feeds the transmit holding register
    task automatic run_frame(input int len, input int nwords, input int period,
                             input bit collide, input logic [15:0] cword, input string tag);
        logic [15:0] m;
        logic [15:0] got;
        logic [15:0] last_rx;
        int ntx;
        int irq0;
        m = 16'((32'd1 << len) - 1);
        ntx = 0;
        irq0 = n_txirq;
        last_rx = rx_data_o;
        if (cfg_mc_en) begin
            for (int t = 0; t < period; t++) begin
                if (tx_mask[t]) begin
                    host_write(tx_words[t]);
                    break;
                end
            end
        end
        @(negedge bclk);
        #1 fs_i = 1'b1;
        rx_sd_i = 1'b0;
        if (collide) begin
            repeat (2) @(posedge clk);
            @(negedge clk);
            tx_wr_i = 1'b1;
            tx_data_i = cword;
            @(negedge clk);
            tx_wr_i = 1'b0;
        end
        for (int w = 0; w < nwords; w++) begin
            int s;
            bit rxen, txen;
            s = w % period;
            rxen = !cfg_mc_en || rx_mask[s];
            txen = !cfg_mc_en || tx_mask[s];
            if (rxen) begin
                rx_exp.push_back(rx_words[s] & m);
                last_rx = rx_words[s] & m;
            end
            got = '0;
            for (int b = 0; b < len; b++) begin
                @(negedge bclk);
                #1 fs_i = 1'b0;
                rx_sd_i = rx_words[s][len-1-b];
                @(posedge bclk);
                #1;
                chk(tx_sd_oe == txen, cfg_mc_en ? "R8 tx enable per slot" : "R4 tx enable",
                    32'(tx_sd_oe), 32'(txen));
                if (txen) got = {got[14:0], tx_sd_o};
                if (b == 0 && txen && cfg_mc_en) begin
                    for (int t = s + 1; t < period && (w + t - s) < nwords; t++) begin
                        if (tx_mask[t]) begin
                            host_write(tx_words[t]);
                            break;
                        end
                    end
                end
            end
            if (txen) begin
                ntx++;
                chk(got == (tx_words[s] & m), tag, 32'(got), 32'(tx_words[s] & m));
            end
            if (cfg_mc_en && !rxen)
                chk(rx_data_o == last_rx, "R7 rx data kept", 32'(rx_data_o), 32'(last_rx));
        end
        @(negedge bclk);
        #1 rx_sd_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(n_txirq - irq0 == ntx, "R4 tx irq count", 32'(n_txirq - irq0), 32'(ntx));
    endtask

    initial begin
        int a, b;
        do_reset();

        // R12 reset state
        chk(rx_irq_o == 1'b0 && tx_irq_o == 1'b0, "R12 irq idle", {rx_irq_o, tx_irq_o}, 0);
        chk(tx_sd_oe == 1'b0, "R12 tx released", 32'(tx_sd_oe), 0);
        chk(tx_underrun_o == 1'b0, "R12 underrun clear", 32'(tx_underrun_o), 0);
        chk(rx_data_o == 16'h0 && sclk_o == 1'b0, "R12 data and clock", {rx_data_o, 15'h0, sclk_o}, 0);

        // R2 internal divider
        cfg_div = 8'd4;
        @(posedge sclk_o);
        @(posedge sclk_o); #1 a = cyc;
        @(posedge sclk_o); #1 b = cyc;
        chk(b - a == 10, "R2 sclk period", 32'(b - a), 10);
        chk(sclk_oe == 1'b1, "R2 clock drive enable", 32'(sclk_oe), 1);
        cfg_div = 8'd2;
        do_reset();

        // R5 / R4 / R3 plain mode, 8-bit words
        cfg_wlen_m1 = 4'd7;
        rx_words[0] = 16'h003C; tx_words[0] = 16'h00A5;
        host_write(16'h00A5);
        run_frame(8, 1, 1, 1'b0, 16'h0, "R4 tx word len 8");
        rx_words[0] = 16'h00C3; tx_words[0] = 16'h005E;
        host_write(16'h005E);
        run_frame(8, 1, 1, 1'b0, 16'h0, "R5 second frame");
        chk(tx_sd_oe == 1'b0, "R5 idle after one word", 32'(tx_sd_oe), 0);
        chk(tx_underrun_o == 1'b0, "R9 no underrun when fed", 32'(tx_underrun_o), 0);

        // R1 word length extremes
        cfg_wlen_m1 = 4'd2;
        rx_words[0] = 16'hFFF6; tx_words[0] = 16'h0005;
        host_write(16'h0005);
        run_frame(3, 1, 1, 1'b0, 16'h0, "R1 tx word len 3");
        cfg_wlen_m1 = 4'd15;
        rx_words[0] = 16'h8001; tx_words[0] = 16'hBEEF;
        host_write(16'hBEEF);
        run_frame(16, 1, 1, 1'b0, 16'h0, "R1 tx word len 16");

        // R9 underrun repeats last word, sticky
        cfg_wlen_m1 = 4'd7;
        rx_words[0] = 16'h0011; tx_words[0] = 16'h00C3;
        host_write(16'h00C3);
        run_frame(8, 1, 1, 1'b0, 16'h0, "R9 fed word");
        chk(tx_underrun_o == 1'b0, "R9 flag before starve", 32'(tx_underrun_o), 0);
        run_frame(8, 1, 1, 1'b0, 16'h0, "R9 repeated word");
        chk(tx_underrun_o == 1'b1, "R9 flag set", 32'(tx_underrun_o), 1);
        tx_words[0] = 16'h0077;
        host_write(16'h0077);
        run_frame(8, 1, 1, 1'b0, 16'h0, "R9 word after refill");
        chk(tx_underrun_o == 1'b1, "R9 flag sticky", 32'(tx_underrun_o), 1);

        // R10 write colliding with load, holding register empty
        do_reset();
        tx_words[0] = 16'h0099;
        run_frame(8, 1, 1, 1'b1, 16'h0099, "R10 bypass word");
        chk(tx_underrun_o == 1'b0, "R10 bypass no underrun", 32'(tx_underrun_o), 0);
        // R10 holding register full
        do_reset();
        host_write(16'h0012);
        tx_words[0] = 16'h0012;
        run_frame(8, 1, 1, 1'b1, 16'h0034, "R10 old word first");
        tx_words[0] = 16'h0034;
        run_frame(8, 1, 1, 1'b0, 16'h0, "R10 new word kept");
        chk(tx_underrun_o == 1'b0, "R10 no underrun", 32'(tx_underrun_o), 0);

        // R6 / R7 / R8 multichannel 24 slots, one wrapped word
        do_reset();
        cfg_mc_en = 1'b1; cfg_mc_32 = 1'b0; cfg_wlen_m1 = 4'd7;
        rx_mask = 32'hFF5A_3C81; tx_mask = 32'hFF96_C35A;
        for (int s = 0; s < 32; s++) begin
            rx_words[s] = 16'(s * 37 + 90);
            tx_words[s] = 16'(~(s * 53 + 7));
        end
        run_frame(8, 25, 24, 1'b0, 16'h0, "R6 tx slot word 24");
        do_reset();

        // R6 multichannel 32 slots, 5-bit words, one wrapped word
        cfg_mc_32 = 1'b1; cfg_wlen_m1 = 4'd4;
        rx_mask = 32'h8421_0F0F; tx_mask = 32'hF0F0_1234;
        run_frame(5, 33, 32, 1'b0, 16'h0, "R6 tx slot word 32");
        do_reset();
        cfg_mc_en = 1'b0; cfg_mc_32 = 1'b0;

        // R11 external serial clock
        cfg_int_clk = 1'b0;
        do_reset();
        chk(sclk_oe == 1'b0, "R2 clock pin released", 32'(sclk_oe), 0);
        cfg_wlen_m1 = 4'd7;
        rx_words[0] = 16'h0069; tx_words[0] = 16'h00B4;
        host_write(16'h00B4);
        run_frame(8, 1, 1, 1'b0, 16'h0, "R11 tx word ext clock");

        chk(rx_exp.size() == 0, "R3 all rx words seen", 32'(rx_exp.size()), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule